// File: doc/BRIEF.md
# Sequential Stream Buffer Prefetcher

This block sits beside a cache and keeps one stream of sequential cache lines in a small FIFO of its own, so that speculative lines never displace lines in the cache. Every lookup the cache performs is also presented here. When the cache missed and the line address equals the line at the head of the stream, the head line is handed to the cache for fill. Consuming the head frees one slot, and the block then requests the line after the current tail, so the stream stays a constant number of lines ahead of the demand access. A cache miss that does not match the head discards the old stream and starts a new one at the missed line plus one.

Line addresses are 26 bits wide (a 32-bit byte address with 64-byte lines), and successive lines differ by one. Prefetch requests leave on a valid/ready channel and carry a generation tag. Responses come back in request order with the same tag and are always accepted (the response channel has no ready). A response whose tag is stale, or whose line is not the next one expected, is dropped. Lookups and fills use valid/ready: a lookup is accepted only while `lk_ready` is high, and a fill is held unchanged until the cache raises `fill_ready`. While a fill is waiting, or while a matched head line is still in flight, or during a flush, `lk_ready` is low and lookups must wait.

Top module: `sbp_stream_prefetcher`

## Requirements
- R1: After reset no stream exists: `req_valid` and `fill_valid` are 0 and `lk_ready` is 1.
- R2: An accepted lookup with `lk_miss`=1 that does not match the head (or finds no stream) replaces the stream with lines A+1 to A+8 for missed line A, and from the next cycle requests them in ascending order, one per `req_valid`/`req_ready` handshake.
- R3: An accepted miss lookup whose line equals the head line with its data arrived raises `lk_hit` in the same cycle; in the next cycle `fill_valid` is 1 with that line and its data, held unchanged until `fill_ready` is 1.
- R4: At most 8 lines are requested ahead of the head; each consumed head line causes exactly one further request, for the line after the current tail.
- R5: An accepted miss lookup that matches the head before its data has arrived raises `lk_pend`; the fill of that line follows one cycle after its response arrives, with no further lookup.
- R6: `lk_ready` is 0 whenever `fill_valid` is 1, a pending head match is waiting, or `flush` is 1.
- R7: `req_gen` increments by one (modulo 8) on every new stream and every flush; a response is dropped unless its `rsp_gen` equals the current `req_gen` and its `rsp_line` is the next line still awaited.
- R8: `flush` discards the stream and any pending match; no request is issued afterwards until a new miss allocates a stream.
- R9: Lookups with `lk_miss`=0 change no state: the generation tag, outstanding requests and the head stay as they were.
- R10: Line arithmetic wraps modulo 2^26: the line after 26'h3FFFFFF is 0.
- R11: While `req_valid` is 1 and `req_ready` is 0, `req_line` and `req_gen` stay stable unless a flush or a new stream intervenes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Discard the stream |
| lk_valid | input | 1 | Lookup presented |
| lk_ready | output | 1 | Lookup can be accepted |
| lk_line | input | 26 | Line address of the lookup |
| lk_miss | input | 1 | The cache missed on this lookup |
| lk_hit | output | 1 | Head matched with data present |
| lk_pend | output | 1 | Head matched, data still in flight |
| req_valid | output | 1 | Prefetch request valid |
| req_ready | input | 1 | Memory side accepts the request |
| req_line | output | 26 | Requested line address |
| req_gen | output | 3 | Generation tag of the request |
| rsp_valid | input | 1 | Response valid (always accepted) |
| rsp_line | input | 26 | Line address of the response |
| rsp_gen | input | 3 | Generation tag echoed by memory |
| rsp_data | input | 64 | Line data |
| fill_valid | output | 1 | Line offered to the cache |
| fill_ready | input | 1 | Cache takes the line |
| fill_line | output | 26 | Line address of the fill |
| fill_data | output | 64 | Line data of the fill |

## Verification
A wrong head pointer or arrival count shows at once as a fill carrying the data of a neighbouring line, or as `lk_hit` and `lk_pend` swapping on the next matched lookup. A lost or duplicated issue count shows on the request channel within one handshake as a skipped or repeated `req_line`, and later as a stream that stops short of eight lines ahead. A generation tag that fails to advance lets stale responses into the FIFO, which surfaces as wrong `fill_data` on the first consumed line of the new stream; every output is compared against a behavioural model on each clock, so each of these faults is reported in the cycle it reaches a port.

// File: rtl/sbp_pkg.sv
`timescale 1ns/1ps
package sbp_pkg;
  // Outcome of probing the stream head with one lookup
  typedef enum logic [1:0] {
    PR_NONE  = 2'd0,  // no accepted miss lookup this cycle
    PR_HIT   = 2'd1,  // head matches, data present
    PR_WAIT  = 2'd2,  // head matches, data still in flight
    PR_ALLOC = 2'd3   // miss elsewhere: start a new stream
  } probe_e;
endpackage

// File: rtl/sbp_head_probe.sv
`timescale 1ns/1ps
module sbp_head_probe
  import sbp_pkg::*;
#(
  parameter int LINE_W = 26
) (
  input  logic              lk_valid,
  input  logic              lk_ready,
  input  logic              lk_miss,
  input  logic [LINE_W-1:0] lk_line,
  input  logic              strm_valid,
  input  logic [LINE_W-1:0] head_line,
  input  logic              head_ready,
  output probe_e            outcome
);

  logic taken;
  logic head_match;

  assign taken      = lk_valid && lk_ready && lk_miss;
  assign head_match = strm_valid && (lk_line == head_line);

  always_comb begin
    if (!taken)          outcome = PR_NONE;
    else if (!head_match) outcome = PR_ALLOC;
    else if (head_ready)  outcome = PR_HIT;
    else                  outcome = PR_WAIT;
  end

endmodule

// File: rtl/sbp_line_store.sv
`timescale 1ns/1ps
module sbp_line_store #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 64
) (
  input  logic                     clk,
  input  logic                     wr_en,
  input  logic [$clog2(DEPTH)-1:0] wr_slot,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic [$clog2(DEPTH)-1:0] rd_slot,
  output logic [DATA_W-1:0]        rd_data
);

  localparam int SLOT_W = $clog2(DEPTH);

  logic [DEPTH-1:0]  wr_hot;
  logic [DATA_W-1:0] slot_q [DEPTH];

  for (genvar s = 0; s < DEPTH; s++) begin : g_dec
    assign wr_hot[s] = wr_en && (wr_slot == SLOT_W'(s));
  end

  always_ff @(posedge clk) begin
    for (int s = 0; s < DEPTH; s++) begin
      if (wr_hot[s]) slot_q[s] <= wr_data;
    end
  end

  assign rd_data = slot_q[rd_slot];

endmodule

// File: rtl/sbp_stream_ctrl.sv
`timescale 1ns/1ps
module sbp_stream_ctrl #(
  parameter int LINE_W = 26,
  parameter int DEPTH  = 8,
  parameter int GEN_W  = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flush,
  input  logic                     do_alloc,
  input  logic [LINE_W-1:0]        alloc_line,
  input  logic                     do_pop,
  input  logic                     set_pend,
  input  logic                     req_ready,
  input  logic                     rsp_valid,
  input  logic [GEN_W-1:0]         rsp_gen,
  input  logic [LINE_W-1:0]        rsp_line,
  output logic                     strm_valid,
  output logic [LINE_W-1:0]        head_line,
  output logic [$clog2(DEPTH)-1:0] head_slot,
  output logic                     head_ready,
  output logic                     pend_q,
  output logic                     req_valid,
  output logic [LINE_W-1:0]        req_line,
  output logic [GEN_W-1:0]         gen,
  output logic                     wr_en,
  output logic [$clog2(DEPTH)-1:0] wr_slot
);

  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_C = CNT_W'(DEPTH);

  logic              valid_q;
  logic [LINE_W-1:0] head_q;
  logic [PTR_W-1:0]  hd_q;
  logic [CNT_W-1:0]  iss_q;   // lines requested, counted from the head
  logic [CNT_W-1:0]  arr_q;   // lines arrived, counted from the head
  logic [GEN_W-1:0]  gen_q;
  logic              pend_r;

  logic              fire;
  logic              match;
  logic [LINE_W-1:0] expect_line;

  assign req_valid   = valid_q && (iss_q != FULL_C);
  assign req_line    = head_q + LINE_W'(iss_q);
  assign fire        = req_valid && req_ready;
  assign expect_line = head_q + LINE_W'(arr_q);
  assign match       = rsp_valid && valid_q && (rsp_gen == gen_q) &&
                       (arr_q != iss_q) && (rsp_line == expect_line);

  assign wr_en      = match;
  assign wr_slot    = hd_q + arr_q[PTR_W-1:0];
  assign strm_valid = valid_q;
  assign head_line  = head_q;
  assign head_slot  = hd_q;
  assign head_ready = (arr_q != '0);
  assign pend_q     = pend_r;
  assign gen        = gen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      head_q  <= '0;
      hd_q    <= '0;
      iss_q   <= '0;
      arr_q   <= '0;
      gen_q   <= '0;
      pend_r  <= 1'b0;
    end else if (flush) begin
      valid_q <= 1'b0;
      iss_q   <= '0;
      arr_q   <= '0;
      gen_q   <= gen_q + 1'b1;
      pend_r  <= 1'b0;
    end else if (do_alloc) begin
      valid_q <= 1'b1;
      head_q  <= alloc_line + 1'b1;
      hd_q    <= '0;
      iss_q   <= '0;
      arr_q   <= '0;
      gen_q   <= gen_q + 1'b1;
    end else begin
      iss_q <= iss_q + CNT_W'(fire)  - CNT_W'(do_pop);
      arr_q <= arr_q + CNT_W'(match) - CNT_W'(do_pop);
      if (do_pop) begin
        head_q <= head_q + 1'b1;
        hd_q   <= hd_q + 1'b1;
        pend_r <= 1'b0;
      end
      if (set_pend) pend_r <= 1'b1;
    end
  end

endmodule

// File: rtl/sbp_stream_prefetcher.sv
`timescale 1ns/1ps
module sbp_stream_prefetcher
  import sbp_pkg::*;
#(
  parameter int LINE_W = 26,
  parameter int DEPTH  = 8,
  parameter int GEN_W  = 3,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [LINE_W-1:0] lk_line,
  input  logic              lk_miss,
  output logic              lk_hit,
  output logic              lk_pend,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [LINE_W-1:0] req_line,
  output logic [GEN_W-1:0]  req_gen,
  input  logic              rsp_valid,
  input  logic [LINE_W-1:0] rsp_line,
  input  logic [GEN_W-1:0]  rsp_gen,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              fill_valid,
  input  logic              fill_ready,
  output logic [LINE_W-1:0] fill_line,
  output logic [DATA_W-1:0] fill_data
);

  localparam int PTR_W = $clog2(DEPTH);

  probe_e            outcome;
  logic              strm_valid;
  logic [LINE_W-1:0] head_line;
  logic [PTR_W-1:0]  head_slot;
  logic              head_ready;
  logic              pend_q;
  logic              wr_en;
  logic [PTR_W-1:0]  wr_slot;
  logic [DATA_W-1:0] head_data;
  logic              pend_done;
  logic              do_pop;

  logic              fill_v_q;
  logic [LINE_W-1:0] fill_l_q;
  logic [DATA_W-1:0] fill_d_q;

  assign lk_ready  = !fill_v_q && !pend_q && !flush;
  assign lk_hit    = (outcome == PR_HIT);
  assign lk_pend   = (outcome == PR_WAIT);
  assign pend_done = pend_q && head_ready && !flush;
  assign do_pop    = lk_hit || pend_done;

  sbp_head_probe #(.LINE_W(LINE_W)) u_probe (
    .lk_valid   (lk_valid),
    .lk_ready   (lk_ready),
    .lk_miss    (lk_miss),
    .lk_line    (lk_line),
    .strm_valid (strm_valid),
    .head_line  (head_line),
    .head_ready (head_ready),
    .outcome    (outcome)
  );

  sbp_stream_ctrl #(.LINE_W(LINE_W), .DEPTH(DEPTH), .GEN_W(GEN_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .do_alloc   (outcome == PR_ALLOC),
    .alloc_line (lk_line),
    .do_pop     (do_pop),
    .set_pend   (lk_pend),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .rsp_gen    (rsp_gen),
    .rsp_line   (rsp_line),
    .strm_valid (strm_valid),
    .head_line  (head_line),
    .head_slot  (head_slot),
    .head_ready (head_ready),
    .pend_q     (pend_q),
    .req_valid  (req_valid),
    .req_line   (req_line),
    .gen        (req_gen),
    .wr_en      (wr_en),
    .wr_slot    (wr_slot)
  );

  sbp_line_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_slot (wr_slot),
    .wr_data (rsp_data),
    .rd_slot (head_slot),
    .rd_data (head_data)
  );

  // Fill register: loaded when the head is consumed, cleared on handshake
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_v_q <= 1'b0;
      fill_l_q <= '0;
      fill_d_q <= '0;
    end else if (do_pop) begin
      fill_v_q <= 1'b1;
      fill_l_q <= head_line;
      fill_d_q <= head_data;
    end else if (fill_ready) begin
      fill_v_q <= 1'b0;
    end
  end

  assign fill_valid = fill_v_q;
  assign fill_line  = fill_l_q;
  assign fill_data  = fill_d_q;

endmodule

// File: rtl/sbp_stream_prefetcher_chk.sv
`timescale 1ns/1ps
module sbp_stream_prefetcher_chk #(
  parameter int LINE_W = 26,
  parameter int GEN_W  = 3,
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flush,
  input logic              lk_valid,
  input logic              lk_ready,
  input logic [LINE_W-1:0] lk_line,
  input logic              lk_miss,
  input logic              lk_hit,
  input logic              lk_pend,
  input logic              req_valid,
  input logic              req_ready,
  input logic [LINE_W-1:0] req_line,
  input logic [GEN_W-1:0]  req_gen,
  input logic              fill_valid,
  input logic              fill_ready,
  input logic [LINE_W-1:0] fill_line,
  input logic [DATA_W-1:0] fill_data
);

  logic new_stream;
  assign new_stream = lk_valid && lk_ready && lk_miss && !lk_hit && !lk_pend;

  // R3
  hit_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready && lk_hit) |=> (fill_valid && fill_line == $past(lk_line)));

  // R3
  fill_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && !fill_ready) |=> (fill_valid && $stable(fill_line) && $stable(fill_data)));

  // R6
  fill_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |-> !lk_ready);

  // R5
  pend_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready && lk_pend) |=> !lk_ready);

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && !flush && !new_stream) |=>
      (req_valid && $stable(req_line) && $stable(req_gen)));

  // R8
  flush_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !req_valid);

  // R9
  gen_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && !(lk_valid && lk_ready && lk_miss)) |=> $stable(req_gen));

endmodule

bind sbp_stream_prefetcher sbp_stream_prefetcher_chk #(
  .LINE_W(LINE_W), .GEN_W(GEN_W), .DATA_W(DATA_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .flush      (flush),
  .lk_valid   (lk_valid),
  .lk_ready   (lk_ready),
  .lk_line    (lk_line),
  .lk_miss    (lk_miss),
  .lk_hit     (lk_hit),
  .lk_pend    (lk_pend),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_line   (req_line),
  .req_gen    (req_gen),
  .fill_valid (fill_valid),
  .fill_ready (fill_ready),
  .fill_line  (fill_line),
  .fill_data  (fill_data)
);

// File: tb/sbp_stream_prefetcher_tb.sv
`timescale 1ns/1ps
module sbp_stream_prefetcher_tb;

  localparam int LW = 26;
  localparam int GW = 3;
  localparam int DW = 64;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          flush = 1'b0;
  logic          lk_valid = 1'b0;
  logic          lk_ready;
  logic [LW-1:0] lk_line = '0;
  logic          lk_miss = 1'b0;
  logic          lk_hit, lk_pend;
  logic          req_valid;
  logic          req_ready = 1'b1;
  logic [LW-1:0] req_line;
  logic [GW-1:0] req_gen;
  logic          rsp_valid = 1'b0;
  logic [LW-1:0] rsp_line = '0;
  logic [GW-1:0] rsp_gen = '0;
  logic [DW-1:0] rsp_data = '0;
  logic          fill_valid;
  logic          fill_ready = 1'b1;
  logic [LW-1:0] fill_line;
  logic [DW-1:0] fill_data;

  sbp_stream_prefetcher u_dut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_line(lk_line), .lk_miss(lk_miss),
    .lk_hit(lk_hit), .lk_pend(lk_pend),
    .req_valid(req_valid), .req_ready(req_ready), .req_line(req_line), .req_gen(req_gen),
    .rsp_valid(rsp_valid), .rsp_line(rsp_line), .rsp_gen(rsp_gen), .rsp_data(rsp_data),
    .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_line(fill_line), .fill_data(fill_data)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  // bench knobs
  int  lat = 4;
  int  req_mode = 0;      // 0: always ready, 1: held low, 2: low one cycle in three
  bit  bogus_req = 0;
  logic [LW-1:0] bogus_line = '0;
  bit  last_acc;

  // reference model state
  bit            m_valid = 0;
  logic [LW-1:0] m_q[$];
  logic [DW-1:0] m_ad[$];
  int            m_iss = 0;
  logic [GW-1:0] m_gen = '0;
  bit            m_pend = 0;
  bit            m_fill_v = 0;
  logic [LW-1:0] m_fill_l = '0;
  logic [DW-1:0] m_fill_d = '0;

  // memory side
  logic [LW-1:0] mem_a[$];
  logic [GW-1:0] mem_g[$];
  int            mem_t[$];
  int            last_due = 0;

  // snapshot of ports taken at the sampling point
  logic          s_lk_ready, s_req_valid, s_fill_valid;
  logic [LW-1:0] s_req_line, s_fill_line;
  logic [GW-1:0] s_req_gen;

  function automatic logic [DW-1:0] line_data(logic [LW-1:0] a, logic [GW-1:0] g);
    return {6'h15, a, 5'h0, g, 24'hC0FFEE ^ a[23:0]};
  endfunction

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s cycle %0d actual=%h expected=%h", tag, what, cyc, act, exp);
    end
  endtask

  task automatic step();
    bit hm, acc, e_hit, e_pend, e_req_v, e_lk_ready, match, pop;
    logic [LW-1:0] e_req_l;
    int n_ad, iss_pre;
    bit pend_pre;
    // memory response for this cycle
    rsp_valid = 1'b0;
    if (bogus_req) begin
      rsp_valid = 1'b1; rsp_line = bogus_line; rsp_gen = m_gen; rsp_data = '1;
      bogus_req = 0;
    end else if (mem_a.size() > 0 && mem_t[0] <= cyc) begin
      rsp_valid = 1'b1; rsp_line = mem_a[0]; rsp_gen = mem_g[0];
      rsp_data = line_data(mem_a[0], mem_g[0]);
      void'(mem_a.pop_front()); void'(mem_g.pop_front()); void'(mem_t.pop_front());
    end
    case (req_mode)
      0: req_ready = 1'b1;
      1: req_ready = 1'b0;
      default: req_ready = (cyc % 3) != 0;
    endcase
    @(negedge clk);
    e_lk_ready = !m_fill_v && !m_pend && !flush;
    hm      = m_valid && (m_q.size() > 0) && (lk_line == m_q[0]);
    acc     = lk_valid && e_lk_ready;
    e_hit   = acc && lk_miss && hm && (m_ad.size() > 0);
    e_pend  = acc && lk_miss && hm && (m_ad.size() == 0);
    e_req_v = m_valid && (m_iss < DEPTH);
    e_req_l = e_req_v ? m_q[m_iss] : '0;
    if (rst_n) begin
      chk("R6", "lk_ready", 64'(lk_ready), 64'(e_lk_ready));
      chk("R3", "lk_hit", 64'(lk_hit), 64'(e_hit));
      chk("R5", "lk_pend", 64'(lk_pend), 64'(e_pend));
      chk("R2", "req_valid", 64'(req_valid), 64'(e_req_v));
      if (e_req_v) chk("R4", "req_line", 64'(req_line), 64'(e_req_l));
      chk("R7", "req_gen", 64'(req_gen), 64'(m_gen));
      chk("R3", "fill_valid", 64'(fill_valid), 64'(m_fill_v));
      if (m_fill_v) begin
        chk("R3", "fill_line", 64'(fill_line), 64'(m_fill_l));
        chk("R7", "fill_data", fill_data, m_fill_d);
      end
    end
    s_lk_ready = lk_ready; s_req_valid = req_valid; s_fill_valid = fill_valid;
    s_req_line = req_line; s_fill_line = fill_line; s_req_gen = req_gen;
    last_acc = acc;
    @(posedge clk);
    if (!rst_n) begin
      m_valid = 0; m_q.delete(); m_ad.delete(); m_iss = 0; m_gen = '0;
      m_pend = 0; m_fill_v = 0; m_fill_l = '0; m_fill_d = '0;
    end else begin
      n_ad = m_ad.size(); iss_pre = m_iss; pend_pre = m_pend;
      if (e_req_v && req_ready) begin
        int due;
        due = cyc + lat;
        if (due <= last_due) due = last_due + 1;
        last_due = due;
        mem_a.push_back(e_req_l); mem_g.push_back(m_gen); mem_t.push_back(due);
        m_iss++;
      end
      match = rsp_valid && m_valid && (rsp_gen == m_gen) && (n_ad < iss_pre) &&
              (rsp_line == m_q[n_ad]);
      if (match) m_ad.push_back(rsp_data);
      if (m_fill_v && fill_ready) m_fill_v = 0;
      pop = !flush && (e_hit || (pend_pre && n_ad > 0));
      if (pop) begin
        logic [LW-1:0] nxt;
        m_fill_v = 1; m_fill_l = m_q[0]; m_fill_d = m_ad[0];
        nxt = m_q[m_q.size()-1] + 26'd1;
        void'(m_q.pop_front()); void'(m_ad.pop_front());
        m_q.push_back(nxt);
        m_iss--; m_pend = 0;
      end
      if (e_pend) m_pend = 1;
      if (acc && lk_miss && !hm) begin
        m_q.delete();
        for (int k = 1; k <= DEPTH; k++) m_q.push_back(LW'(lk_line + LW'(k)));
        m_iss = 0; m_ad.delete(); m_gen = m_gen + 1'b1; m_valid = 1;
      end
      if (flush) begin
        m_valid = 0; m_q.delete(); m_ad.delete(); m_iss = 0;
        m_gen = m_gen + 1'b1; m_pend = 0;
      end
    end
    cyc++;
    #1;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic lookup(logic [LW-1:0] a, logic miss);
    int tries;
    lk_valid = 1'b1; lk_line = a; lk_miss = miss;
    tries = 0;
    do begin
      step();
      tries++;
    end while (!last_acc && tries < 300);
    if (!last_acc) begin
      checks++; fails++;
      $display("FAIL R6 lookup %h never accepted actual=0 expected=1", a);
    end
    lk_valid = 1'b0;
  endtask

  initial begin
    logic [GW-1:0] g0;
    logic [LW-1:0] held;
    idle(3);
    rst_n = 1'b1;
    step();
    // R1: reset state
    chk("R1", "req_valid after reset", 64'(s_req_valid), 64'd0);
    chk("R1", "fill_valid after reset", 64'(s_fill_valid), 64'd0);
    chk("R1", "lk_ready after reset", 64'(s_lk_ready), 64'd1);

    // R2/R4: allocate, fill the stream, consume sequentially
    lat = 4;
    lookup(26'd100, 1'b1);
    idle(14);
    chk("R4", "no request beyond depth", 64'(s_req_valid), 64'd0);
    for (int k = 1; k <= 12; k++) lookup(LW'(100 + k), 1'b1);
    idle(12);

    // R9: cache-hit lookups leave everything alone
    g0 = s_req_gen;
    for (int k = 0; k < 3; k++) lookup(26'd113, 1'b0);
    lookup(26'd140, 1'b0);
    step();
    chk("R9", "gen after hit lookups", 64'(s_req_gen), 64'(g0));
    chk("R9", "no new request", 64'(s_req_valid), 64'd0);
    lookup(26'd113, 1'b1);
    step();
    chk("R9", "head still 113", 64'(s_fill_line), 64'd113);

    // R5: head matched before data arrives
    lat = 25;
    lookup(26'd500, 1'b1);
    lookup(26'd501, 1'b1);
    for (int k = 502; k <= 505; k++) lookup(LW'(k), 1'b1);
    idle(40);

    // R6: fill back-pressure blocks lookups
    fill_ready = 1'b0;
    lookup(26'd506, 1'b1);
    idle(4);
    chk("R6", "lk_ready under fill stall", 64'(s_lk_ready), 64'd0);
    chk("R3", "fill held", 64'(s_fill_line), 64'd506);
    fill_ready = 1'b1;
    idle(2);

    // R11: request channel back-pressure
    lat = 3;
    req_mode = 1;
    lookup(26'd800, 1'b1);
    step();
    held = s_req_line;
    idle(4);
    chk("R11", "req_line stable", 64'(s_req_line), 64'(held));
    chk("R11", "req_valid held", 64'(s_req_valid), 64'd1);
    req_mode = 2;
    for (int k = 801; k <= 810; k++) lookup(LW'(k), 1'b1);
    req_mode = 0;
    idle(6);

    // R7: reallocation with responses in flight, then a bogus response
    lat = 15;
    lookup(26'd900, 1'b1);
    idle(4);
    lookup(26'd2000, 1'b1);
    for (int k = 2001; k <= 2004; k++) lookup(LW'(k), 1'b1);
    lookup(26'd3000, 1'b1);
    idle(2);
    bogus_line = 26'h123;
    bogus_req = 1;
    for (int k = 3001; k <= 3003; k++) lookup(LW'(k), 1'b1);
    idle(20);

    // R8: flush, including a flush during a pending match
    flush = 1'b1; step(); flush = 1'b0;
    idle(20);
    chk("R8", "no request after flush", 64'(s_req_valid), 64'd0);
    lat = 20;
    lookup(26'd4000, 1'b1);
    lookup(26'd4001, 1'b1);
    flush = 1'b1; step(); flush = 1'b0;
    idle(30);
    chk("R8", "pending cleared by flush", 64'(s_lk_ready), 64'd1);
    lookup(26'd4001, 1'b1);
    idle(6);

    // R10: wrap at the top of the line space
    lat = 3;
    lookup(26'h3FFFFFE, 1'b1);
    idle(15);
    lookup(26'h3FFFFFF, 1'b1);
    lookup(26'h0, 1'b1);
    step();
    chk("R10", "fill after wrap", 64'(s_fill_line), 64'd0);
    idle(10);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog all requirements actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule